// File: doc/BRIEF.md
# Lane-Indexed Vector Operand Shuffler

This block gathers operands for an eight-lane arithmetic stage. It takes a wide X buffer of 32-bit words and a narrow Z buffer of eight 32-bit words. For each buffer it also takes a shared start index and one 32-bit word that packs a 4-bit offset for every lane. Each output lane reads the buffer word at the start plus that lane's offset. The index wraps at the buffer length. Two scalar values are therefore enough to describe any gather pattern: broadcast, rotation, reversal or sliding window.

The block has two modes. In real mode each of the eight lanes selects one 32-bit word. In complex mode the buffers are treated as real/imaginary word pairs. There are then four lanes, and each lane selects a 64-bit pair. The X buffer can be used at its full length of 32 words or at half length of 16 words. The two gathered 256-bit vectors are registered and appear one clock after a valid input, together with a valid flag.

Top module: `vec_gather`

## Requirements
- R1: In real mode with the full X length, output word w of `x_vec` (bits 32w+31..32w) equals X word (x_start + off_w) mod 32. Here off_w is bits 4w+3..4w of `x_offs`, so lane 0 is the least significant nibble.
- R2: When `x_half` is 1, X indexes wrap modulo 16, and X words 16..31 never reach the output.
- R3: Output word w of `z_vec` equals Z word (z_start + off_w) mod 8, with off_w taken from `z_offs` in the same way as R1.
- R4: The index sum is formed at full width before wrapping, so a sum above 15 reaches the upper X words. For example, start 2 with offsets 0x210FEDCB gives X words 0xD, 0xE, 0xF, 0x10, 0x11, 0x2, 0x3, 0x4 on lanes 0..7.
- R5: In complex mode (`cplx`=1), pair lane k (k = 0..3) uses offset nibble k, and nibbles 4..7 are ignored. The pair index is p = (start + nibble k) wrapped at 16 pairs for full X, 8 pairs for half X, and 4 pairs for Z. Output words 2k and 2k+1 receive buffer words 2p (real part) and 2p+1 (imaginary part).
- R6: `out_valid` is 1 exactly on the clock after a clock with `in_valid` = 1, and the vectors then show that input's gather.
- R7: When `in_valid` is 0, `x_vec` and `z_vec` keep their previous values, whatever the other inputs do.
- R8: While `rst_n` is low, `out_valid`, `x_vec` and `z_vec` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture this cycle's gather |
| cplx | input | 1 | 1 selects complex pair mode |
| x_half | input | 1 | 1 uses only X words 0..15 |
| x_buf | input | 1024 | X buffer, word n at bits 32n+31..32n |
| x_start | input | 8 | Shared start index for X |
| x_offs | input | 32 | Packed 4-bit per-lane X offsets |
| z_buf | input | 256 | Z buffer, word n at bits 32n+31..32n |
| z_start | input | 8 | Shared start index for Z |
| z_offs | input | 32 | Packed 4-bit per-lane Z offsets |
| out_valid | output | 1 | Registered valid flag |
| x_vec | output | 256 | Gathered X operand vector |
| z_vec | output | 256 | Gathered Z operand vector |

## Verification
The bench builds the block with its default parameters: eight 32-bit lanes, a 32-word X buffer and an 8-word Z buffer. With these values, random 8-bit starts plus offsets up to 15 wrap around every buffer length, including the 16-word half X and the 4-pair complex Z. The upper X words stay filled with distinct data, so a half-length gather that wrongly reaches them shows up at once. Eight-bit starts near 255 also exercise the wrap of the start register itself.

// File: rtl/vec_gather.sv
module vec_gather #(
  parameter int WORD_W  = 32,
  parameter int LANES   = 8,
  parameter int X_WORDS = 32,
  parameter int Z_WORDS = 8,
  parameter int OFF_W   = 4,
  parameter int START_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       cplx,
  input  logic                       x_half,
  input  logic [X_WORDS*WORD_W-1:0]  x_buf,
  input  logic [START_W-1:0]         x_start,
  input  logic [LANES*OFF_W-1:0]     x_offs,
  input  logic [Z_WORDS*WORD_W-1:0]  z_buf,
  input  logic [START_W-1:0]         z_start,
  input  logic [LANES*OFF_W-1:0]     z_offs,
  output logic                       out_valid,
  output logic [LANES*WORD_W-1:0]    x_vec,
  output logic [LANES*WORD_W-1:0]    z_vec
);
  localparam int XI_W = $clog2(X_WORDS);
  localparam int ZI_W = $clog2(Z_WORDS);
  localparam int VW   = LANES*WORD_W;

  logic [VW-1:0] x_next, z_next;

  for (genvar w = 0; w < LANES; w++) begin : g_word
    localparam int PL = w / 2;
    localparam logic ODD = 1'(w % 2);
    logic [OFF_W-1:0]   xo, zo;
    logic [START_W-1:0] xs, zs;
    logic [XI_W-1:0]    xi;
    logic [ZI_W-1:0]    zi;

    assign xo = cplx ? x_offs[PL*OFF_W +: OFF_W] : x_offs[w*OFF_W +: OFF_W];
    assign zo = cplx ? z_offs[PL*OFF_W +: OFF_W] : z_offs[w*OFF_W +: OFF_W];
    assign xs = x_start + START_W'(xo);
    assign zs = z_start + START_W'(zo);

    assign xi = cplx ? {xs[XI_W-2] & ~x_half, xs[XI_W-3:0], ODD}
                     : {xs[XI_W-1] & ~x_half, xs[XI_W-2:0]};
    assign zi = cplx ? {zs[ZI_W-2:0], ODD} : zs[ZI_W-1:0];

    assign x_next[w*WORD_W +: WORD_W] = x_buf[32'(xi)*WORD_W +: WORD_W];
    assign z_next[w*WORD_W +: WORD_W] = z_buf[32'(zi)*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      x_vec     <= '0;
      z_vec     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        x_vec <= x_next;
        z_vec <= z_next;
      end
    end
  end
endmodule

// File: rtl/vec_gather_chk.sv
module vec_gather_chk #(
  parameter int WORD_W  = 32,
  parameter int LANES   = 8,
  parameter int X_WORDS = 32,
  parameter int Z_WORDS = 8,
  parameter int OFF_W   = 4,
  parameter int START_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       cplx,
  input logic                       x_half,
  input logic [X_WORDS*WORD_W-1:0]  x_buf,
  input logic [START_W-1:0]         x_start,
  input logic [LANES*OFF_W-1:0]     x_offs,
  input logic [Z_WORDS*WORD_W-1:0]  z_buf,
  input logic [START_W-1:0]         z_start,
  input logic [LANES*OFF_W-1:0]     z_offs,
  input logic                       out_valid,
  input logic [LANES*WORD_W-1:0]    x_vec,
  input logic [LANES*WORD_W-1:0]    z_vec
);
  p_valid_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(x_vec) && $stable(z_vec)));
  p_reset_r8: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && x_vec == '0 && z_vec == '0));
  p_x_lane0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cplx && !x_half) |=>
      x_vec[WORD_W-1:0] == $past(x_buf[((int'(x_start) + int'(x_offs[OFF_W-1:0])) % X_WORDS)*WORD_W +: WORD_W]));
  p_z_lane7_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cplx) |=>
      z_vec[(LANES-1)*WORD_W +: WORD_W] ==
        $past(z_buf[((int'(z_start) + int'(z_offs[(LANES-1)*OFF_W +: OFF_W])) % Z_WORDS)*WORD_W +: WORD_W]));
  p_x_pair1_imag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cplx && !x_half) |=>
      x_vec[3*WORD_W +: WORD_W] ==
        $past(x_buf[(2*((int'(x_start) + int'(x_offs[OFF_W +: OFF_W])) % (X_WORDS/2)) + 1)*WORD_W +: WORD_W]));
endmodule

bind vec_gather vec_gather_chk #(
  .WORD_W(WORD_W), .LANES(LANES), .X_WORDS(X_WORDS),
  .Z_WORDS(Z_WORDS), .OFF_W(OFF_W), .START_W(START_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cplx(cplx), .x_half(x_half),
  .x_buf(x_buf), .x_start(x_start), .x_offs(x_offs), .z_buf(z_buf),
  .z_start(z_start), .z_offs(z_offs), .out_valid(out_valid),
  .x_vec(x_vec), .z_vec(z_vec)
);

// File: tb/vec_gather_test.sv
`timescale 1ns/1ps
module vec_gather_test;
  logic          clk = 0;
  logic          rst_n = 0;
  logic          in_valid = 0, cplx = 0, x_half = 0;
  logic [1023:0] x_buf = '0;
  logic [255:0]  z_buf = '0;
  logic [7:0]    x_start = 0, z_start = 0;
  logic [31:0]   x_offs = 0, z_offs = 0;
  logic          out_valid;
  logic [255:0]  x_vec, z_vec;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  vec_gather uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cplx(cplx), .x_half(x_half),
    .x_buf(x_buf), .x_start(x_start), .x_offs(x_offs), .z_buf(z_buf),
    .z_start(z_start), .z_offs(z_offs), .out_valid(out_valid),
    .x_vec(x_vec), .z_vec(z_vec)
  );

  function automatic logic [255:0] gather(input logic [1023:0] b, input int len,
      input logic [7:0] s, input logic [31:0] o, input logic c);
    logic [255:0] r;
    for (int w = 0; w < 8; w++) begin
      int lane, sum, idx;
      lane = c ? w / 2 : w;
      sum  = int'(s) + int'(o[lane*4 +: 4]);
      idx  = c ? 2 * (sum % (len / 2)) + w % 2 : sum % len;
      r[w*32 +: 32] = b[idx*32 +: 32];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < 32; i++) x_buf[i*32 +: 32] = $urandom;
    for (int i = 0; i < 8; i++)  z_buf[i*32 +: 32] = $urandom;
  endtask

  task automatic run_one(input string tag);
    logic [255:0] ex, ez;
    ex = gather(x_buf, x_half ? 16 : 32, x_start, x_offs, cplx);
    ez = gather({768'b0, z_buf}, 8, z_start, z_offs, cplx);
    in_valid = 1;
    @(posedge clk); #1;
    chk({tag, " X"}, x_vec, ex);
    chk({tag, " Z"}, z_vec, ez);
    chk({tag, " valid R6"}, {255'b0, out_valid}, 256'd1);
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    #5000000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] hx, hz, ev;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) x_buf[i*32 +: 32] = 32'h1000 + i;
    for (int i = 0; i < 8; i++)  z_buf[i*32 +: 32] = 32'h2000 + i;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset valid", {255'b0, out_valid}, 256'd0);
    chk("R8 reset x", x_vec, '0);
    chk("R8 reset z", z_vec, '0);
    @(negedge clk); rst_n = 1;

    // R4 directed: sum above 15 reaches upper X words
    x_start = 2; x_offs = 32'h210FEDCB; z_start = 7; z_offs = 32'h76543210;
    ev = '0;
    begin
      int xw[8] = '{'hD, 'hE, 'hF, 'h10, 'h11, 2, 3, 4};
      for (int w = 0; w < 8; w++) ev[w*32 +: 32] = 32'h1000 + xw[w];
    end
    in_valid = 1;
    @(posedge clk); #1;
    chk("R4 directed X", x_vec, ev);
    for (int w = 0; w < 8; w++) ev[w*32 +: 32] = 32'h2000 + (7 + w) % 8;
    chk("R3 directed Z wrap", z_vec, ev);
    @(negedge clk); in_valid = 0;

    // R2 half X: same start lands below 16
    x_half = 1;
    run_one("R2 half directed");
    x_half = 0;

    // R5 complex, broadcast and upper nibbles ignored
    cplx = 1; x_start = 15; x_offs = 32'hFFFF0001; z_start = 3; z_offs = 32'hABCD3210;
    run_one("R5 complex directed");
    cplx = 0;

    // R7 hold: change all inputs with in_valid low
    hx = x_vec; hz = z_vec;
    fill_random(); x_start = 8'h55; x_offs = $urandom; z_offs = $urandom;
    @(posedge clk); #1;
    chk("R7 hold X", x_vec, hx);
    chk("R7 hold Z", z_vec, hz);
    chk("R6 valid low", {255'b0, out_valid}, 256'd0);
    @(negedge clk);

    // random mix covering R1, R2, R3, R5
    for (int n = 0; n < 400; n++) begin
      fill_random();
      x_start = 8'($urandom); z_start = 8'($urandom);
      x_offs = $urandom; z_offs = $urandom;
      cplx = 1'($urandom); x_half = 1'($urandom);
      if (!cplx && !x_half) run_one("R1 random");
      else if (!cplx)       run_one("R2 random");
      else                  run_one("R5 random");
      if (n % 7 == 0) begin
        hx = x_vec; hz = z_vec;
        fill_random();
        @(posedge clk); #1;
        chk("R7 random hold X", x_vec, hx);
        chk("R7 random hold Z", z_vec, hz);
        @(negedge clk);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule